// File: doc/BRIEF.md
# Debug Breakpoint Match Unit

This unit keeps four debug address slots and one control word that gives every slot a match type, a length and two enable bits. In each evaluation cycle it compares every slot with the current instruction pointer (execute slots) or with the data access on the access bus (watch slots). From the result it builds the hit field of a debug status register and raises a one-cycle debug trap request.

A hit is recorded in the status register even when its slot is disabled. The new status value is kept only when at least one enabled slot hits, or when the caller forces the update. I/O-type slots are decoded but never hit. A core pipeline drives `evalEn` once per retired instruction or data access. It reads `statusOut` when it services the trap and rewrites the slots through the register write port.

Top module: `dbg_trap_match`

## Requirements
- R1: After reset every slot address is zero, every slot is disabled with execute type and 1-byte length, and `statusOut` reads 0xFFFF0FF0. Bits 4..11 and 16..31 of the status are fixed ones. `trapPulse` is low.
- R2: A write with `regWrEn` high updates the register chosen by `regWrSel`: 0..3 picks a slot address, 4 the status, 5 the control word, and 6 or 7 changes nothing. A status write stores the data ORed with the fixed-one mask. A write is visible from the next cycle on, so an evaluation in the same cycle still sees the old value.
- R3: Type 0 (execute) hits when the full slot address equals `instPtr`. Length and the access bus play no part.
- R4: Type 1 hits only on an access with `accWrite` high that overlaps the slot range.
- R5: Type 3 hits on any overlapping access, read or write.
- R6: Type 2 (I/O) never hits.
- R7: The slot range is the slot address rounded down to the slot length. Length code 00 selects 1 byte, 01 selects 2 bytes, 11 selects 4 bytes and 10 selects 8 bytes. The access covers 2^`accSize` bytes starting at `accAddr`. A hit needs at least one shared byte.
- R8: On a committed evaluation, status bits 3..0 are replaced by the hit vector of slots 3..0, disabled slots included. The other status bits are left alone.
- R9: The status commits only when `evalEn` is high and either an enabled slot hits or `forceUpd` is high. Otherwise it holds its value.
- R10: `trapPulse` is high for exactly the cycle after an evaluation in which an enabled slot hits, and low otherwise.
- R11: Slot i is enabled when control bit 2i or bit 2i+1 is set. Its type sits in bits 17+4i:16+4i and its length code in bits 19+4i:18+4i.
- R12: While `accValid` is low, no watch slot (types 1 and 3) hits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrSel | input | 3 | Register select (0..3 slot, 4 status, 5 control) |
| regWrData | input | ADDR_W | Register write data |
| instPtr | input | ADDR_W | Current instruction pointer |
| accValid | input | 1 | Data access present |
| accAddr | input | ADDR_W | Data access start address |
| accSize | input | 2 | log2 of access bytes |
| accWrite | input | 1 | Access is a write |
| evalEn | input | 1 | Evaluate the slots this cycle |
| forceUpd | input | 1 | Commit the status even without an enabled hit |
| statusOut | output | 32 | Debug status register |
| trapPulse | output | 1 | Debug trap request, one cycle |

## Verification
A wrong slot address, control field or length decode shows up as a wrong hit bit in `statusOut`. It is visible one cycle after the first evaluation that the bench forces or that hits an enabled slot. A wrong enable decode shows the same way, and also as a missing or spurious `trapPulse` in that same cycle. A status register that commits when it should hold keeps the fault in the low bits until the next forced evaluation, so the sweep alternates forced and unforced evaluations to catch it right away.

// File: rtl/dbg_trap_pkg.sv
package dbg_trap_pkg;

  localparam int NUM_SLOTS   = 4;
  localparam int STAT_W      = 32;
  localparam int TYPE_LSB    = 16;
  localparam int LEN_LSB     = 18;
  localparam int FIELD_PITCH = 4;
  localparam logic [STAT_W-1:0] STATUS_ONES = 32'hFFFF_0FF0;

  typedef enum logic [1:0] {
    BP_EXEC  = 2'd0,
    BP_WRITE = 2'd1,
    BP_IO    = 2'd2,
    BP_RW    = 2'd3
  } bpType_t;

  typedef struct packed {
    logic [NUM_SLOTS-1:0] wrAddr;
    logic                 wrStatus;
    logic                 wrCtrl;
    logic                 commit;
  } dbgStrb_t;

  // byte-span mask of a slot: code 00=1B, 01=2B, 11=4B, 10=8B
  function automatic logic [3:0] lenMask(input logic [1:0] code);
    case (code)
      2'b00:   lenMask = 4'd0;
      2'b01:   lenMask = 4'd1;
      2'b11:   lenMask = 4'd3;
      default: lenMask = 4'd7;
    endcase
  endfunction

  function automatic logic [3:0] sizeMask(input logic [1:0] sz);
    sizeMask = (4'd1 << sz) - 4'd1;
  endfunction

endpackage

// File: rtl/dbg_trap_ctrl.sv
module dbg_trap_ctrl
  import dbg_trap_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [2:0]           regWrSel,
  input  logic                 evalEn,
  input  logic                 forceUpd,
  input  logic [NUM_SLOTS-1:0] hitVec,
  input  logic [NUM_SLOTS-1:0] enVec,
  output dbgStrb_t             strb,
  output logic                 trapPulse
);

  logic enabledHit;

  assign enabledHit = |(hitVec & enVec);

  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      strb.wrAddr[i] = regWrEn && (regWrSel == 3'(i));
    end
    strb.wrStatus = regWrEn && (regWrSel == 3'd4);
    strb.wrCtrl   = regWrEn && (regWrSel == 3'd5);
    strb.commit   = evalEn && (enabledHit || forceUpd);
  end

  always_ff @(posedge clk) begin
    if (!rstN) trapPulse <= 1'b0;
    else       trapPulse <= evalEn && enabledHit;
  end

  // R10: a trap is only ever raised after a cycle that committed the status
  p_trap_after_commit_r10: assert property (@(posedge clk) disable iff (!rstN)
    trapPulse |-> $past(strb.commit));

  // R2: reserved selects never yield a write strobe
  p_reserved_sel_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regWrSel[2:1] == 2'b11) |-> !(strb.wrStatus || strb.wrCtrl || |strb.wrAddr));

endmodule

// File: rtl/dbg_trap_dpath.sv
module dbg_trap_dpath
  import dbg_trap_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dbgStrb_t             strb,
  input  logic [ADDR_W-1:0]    regWrData,
  input  logic [ADDR_W-1:0]    instPtr,
  input  logic                 accValid,
  input  logic [ADDR_W-1:0]    accAddr,
  input  logic [1:0]           accSize,
  input  logic                 accWrite,
  output logic [NUM_SLOTS-1:0] hitVec,
  output logic [NUM_SLOTS-1:0] enVec,
  output logic [STAT_W-1:0]    statusOut
);

  localparam int EN_W  = 2 * NUM_SLOTS;
  localparam int FLD_W = FIELD_PITCH * NUM_SLOTS;
  localparam int EXT_W = ADDR_W + 1;

  logic [ADDR_W-1:0] slotAddr [NUM_SLOTS];
  logic [EN_W-1:0]   ctrlEn;
  logic [FLD_W-1:0]  ctrlFld;
  logic [STAT_W-1:0] statusReg;
  logic [EXT_W-1:0]  accStart;
  logic [EXT_W-1:0]  accEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SLOTS; i++) slotAddr[i] <= '0;
      ctrlEn  <= '0;
      ctrlFld <= '0;
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (strb.wrAddr[i]) slotAddr[i] <= regWrData;
      end
      if (strb.wrCtrl) begin
        ctrlEn  <= regWrData[EN_W-1:0];
        ctrlFld <= regWrData[TYPE_LSB +: FLD_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              statusReg <= STATUS_ONES;
    else if (strb.wrStatus) statusReg <= regWrData[STAT_W-1:0] | STATUS_ONES;
    else if (strb.commit)   statusReg <= {statusReg[STAT_W-1:NUM_SLOTS], hitVec};
  end

  assign statusOut = statusReg;
  assign accStart  = {1'b0, accAddr};
  assign accEnd    = accStart + EXT_W'(sizeMask(accSize));

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlot
    bpType_t          slotType;
    logic [3:0]       spanMask;
    logic [ADDR_W-1:0] slotBase;
    logic [EXT_W-1:0] slotEnd;
    logic             overlap;

    assign slotType = bpType_t'(ctrlFld[FIELD_PITCH*g +: 2]);
    assign spanMask = lenMask(ctrlFld[FIELD_PITCH*g + 2 +: 2]);
    assign slotBase = slotAddr[g] & ~ADDR_W'(spanMask);
    assign slotEnd  = {1'b0, slotBase} + EXT_W'(spanMask);
    assign overlap  = accValid && (accStart <= slotEnd) && ({1'b0, slotBase} <= accEnd);
    assign enVec[g] = |ctrlEn[2*g +: 2];

    always_comb begin
      case (slotType)
        BP_EXEC:  hitVec[g] = (slotAddr[g] == instPtr);
        BP_WRITE: hitVec[g] = overlap && accWrite;
        BP_RW:    hitVec[g] = overlap;
        default:  hitVec[g] = 1'b0;
      endcase
    end

    // R6: an I/O slot never reports a hit
    p_io_silent_r6: assert property (@(posedge clk) disable iff (!rstN)
      (slotType == BP_IO) |-> !hitVec[g]);

    // R12: watch slots stay quiet without a data access
    p_no_access_r12: assert property (@(posedge clk) disable iff (!rstN)
      (!accValid && slotType != BP_EXEC) |-> !hitVec[g]);
  end

  // R9: status holds unless committed or written
  p_status_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.commit && !strb.wrStatus) |=> $stable(statusReg));

  // R8: a commit leaves all bits above the hit field untouched
  p_upper_kept_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && !strb.wrStatus) |=>
      (statusReg[STAT_W-1:NUM_SLOTS] == $past(statusReg[STAT_W-1:NUM_SLOTS])));

  // R1: fixed-one bits are always set
  p_fixed_ones_r1: assert property (@(posedge clk) disable iff (!rstN)
    (statusReg & STATUS_ONES) == STATUS_ONES);

endmodule

// File: rtl/dbg_trap_match.sv
module dbg_trap_match
  import dbg_trap_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regWrSel,
  input  logic [ADDR_W-1:0] regWrData,
  input  logic [ADDR_W-1:0] instPtr,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [1:0]        accSize,
  input  logic              accWrite,
  input  logic              evalEn,
  input  logic              forceUpd,
  output logic [31:0]       statusOut,
  output logic              trapPulse
);

  dbgStrb_t             strb;
  logic [NUM_SLOTS-1:0] hitVec;
  logic [NUM_SLOTS-1:0] enVec;

  dbg_trap_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regWrSel  (regWrSel),
    .evalEn    (evalEn),
    .forceUpd  (forceUpd),
    .hitVec    (hitVec),
    .enVec     (enVec),
    .strb      (strb),
    .trapPulse (trapPulse)
  );

  dbg_trap_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .regWrData (regWrData),
    .instPtr   (instPtr),
    .accValid  (accValid),
    .accAddr   (accAddr),
    .accSize   (accSize),
    .accWrite  (accWrite),
    .hitVec    (hitVec),
    .enVec     (enVec),
    .statusOut (statusOut)
  );

endmodule

// File: tb/dbg_trap_match_tb.sv
module dbg_trap_match_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] FIXED = 32'hFFFF_0FF0;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic [2:0]  regWrSel;
  logic [31:0] regWrData;
  logic [31:0] instPtr;
  logic        accValid;
  logic [31:0] accAddr;
  logic [1:0]  accSize;
  logic        accWrite;
  logic        evalEn;
  logic        forceUpd;
  logic [31:0] statusOut;
  logic        trapPulse;

  int checks = 0;
  int errors = 0;

  logic [31:0] mAddr [4];
  logic [31:0] mCtrl;
  logic [31:0] mStatus;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_trap_match u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrSel(regWrSel),
    .regWrData(regWrData), .instPtr(instPtr), .accValid(accValid),
    .accAddr(accAddr), .accSize(accSize), .accWrite(accWrite),
    .evalEn(evalEn), .forceUpd(forceUpd), .statusOut(statusOut),
    .trapPulse(trapPulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit modelHit(input int i, input logic [31:0] ip, input bit v,
                                  input logic [31:0] a, input logic [1:0] sz, input bit w);
    int unsigned typ = (mCtrl >> (16 + 4*i)) & 3;
    int unsigned ln  = (mCtrl >> (18 + 4*i)) & 3;
    longint bytes    = (ln == 0) ? 1 : (ln == 1) ? 2 : (ln == 3) ? 4 : 8;
    longint base     = (longint'(mAddr[i]) / bytes) * bytes;
    longint sEnd     = base + bytes - 1;
    longint aBeg     = longint'(a);
    longint aEnd     = aBeg + (longint'(1) << sz) - 1;
    bit     ovl      = v && (aBeg <= sEnd) && (base <= aEnd);
    case (typ)
      0:       return mAddr[i] == ip;
      1:       return ovl && w;
      3:       return ovl;
      default: return 1'b0;
    endcase
  endfunction

  task automatic wrReg(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regWrSel = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
    if (sel < 4)       mAddr[sel] = data;
    else if (sel == 4) mStatus = data | FIXED;
    else if (sel == 5) mCtrl = data;
  endtask

  task automatic doEval(input logic [31:0] ip, input bit v, input logic [31:0] a,
                        input logic [1:0] sz, input bit w, input bit frc, input string tag);
    logic [3:0] hits;
    bit enHit;
    logic [31:0] expStat;
    @(negedge clk);
    instPtr = ip; accValid = v; accAddr = a; accSize = sz; accWrite = w;
    forceUpd = frc; evalEn = 1'b1;
    enHit = 1'b0;
    for (int i = 0; i < 4; i++) begin
      hits[i] = modelHit(i, ip, v, a, sz, w);
      if (hits[i] && (mCtrl[2*i] || mCtrl[2*i+1])) enHit = 1'b1;
    end
    expStat = (enHit || frc) ? {mStatus[31:4], hits} : mStatus;
    @(negedge clk);
    evalEn = 1'b0; forceUpd = 1'b0; accValid = 1'b0;
    chk({tag, " R8 R9 status"}, statusOut, expStat);
    chk({tag, " R10 trap"}, {31'd0, trapPulse}, {31'd0, enHit});
    mStatus = statusOut;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; regWrEn = 1'b0; regWrSel = '0; regWrData = '0;
    instPtr = '0; accValid = 1'b0; accAddr = '0; accSize = '0;
    accWrite = 1'b0; evalEn = 1'b0; forceUpd = 1'b0;
    for (int i = 0; i < 4; i++) mAddr[i] = '0;
    mCtrl = '0; mStatus = FIXED;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 status reset", statusOut, 32'hFFFF_0FF0);
    chk("R1 trap reset", {31'd0, trapPulse}, 32'd0);
    // R1: zero addresses, disabled exec slots all hit ip 0 and are recorded
    doEval(32'h0, 1'b0, 32'h0, 2'd0, 1'b0, 1'b1, "R1 R3");
    chk("R1 R8 disabled hits recorded", statusOut, 32'hFFFF_0FFF);

    // R2 status write ORs fixed ones
    wrReg(3'd4, 32'h0000_A005);
    chk("R2 status write", statusOut, 32'hFFFF_AFF5);
    wrReg(3'd4, 32'h0);
    chk("R2 status clear", statusOut, 32'hFFFF_0FF0);

    // R2 reserved select 6 and 7: no effect on status or on control
    wrReg(3'd6, 32'h0000_00FF);
    wrReg(3'd7, 32'h0000_00FF);
    chk("R2 sel6/7 status kept", statusOut, 32'hFFFF_0FF0);
    doEval(32'h0, 1'b0, 32'h0, 2'd0, 1'b0, 1'b0, "R2 reserved ctrl");
    chk("R2 R11 sel 7 left slots disabled", {31'd0, trapPulse}, 32'd0);

    // R2 write seen the next cycle, not the same cycle
    @(negedge clk);
    regWrEn = 1'b1; regWrSel = 3'd1; regWrData = 32'h2222;
    instPtr = 32'h2222; evalEn = 1'b1; forceUpd = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; evalEn = 1'b0; forceUpd = 1'b0;
    chk("R2 same-cycle uses old addr", statusOut, 32'hFFFF_0FF0);
    mAddr[1] = 32'h2222; mStatus = statusOut;
    doEval(32'h2222, 1'b0, 32'h0, 2'd0, 1'b0, 1'b1, "R2 R3 next cycle");
    chk("R2 new addr visible", statusOut, 32'hFFFF_0FF2);

    // park slots 1..3 away from the sweep region
    for (int i = 1; i < 4; i++) wrReg(3'(i), 32'hF000_0000 + 32'(i) * 32'h100);
    wrReg(3'd0, 32'h0000_1003);

    // near-exhaustive sweep of slot 0: type, length, enable, offset, size, direction
    for (int t = 0; t < 4; t++) begin
      for (int l = 0; l < 4; l++) begin
        for (int e = 0; e < 4; e++) begin
          wrReg(3'd5, 32'(e) | (32'(t) << 16) | (32'(l) << 18));
          for (int off = -9; off <= 9; off++) begin
            for (int sz = 0; sz < 4; sz++) begin
              for (int w = 0; w < 2; w++) begin
                doEval(32'h1000 + 32'(off), 1'b1, 32'h1000 + 32'(off), 2'(sz), w[0],
                       ((off + sz + w) % 3) == 0,
                       (t == 0) ? "R3 R11" : (t == 1) ? "R4 R7 R11" :
                       (t == 2) ? "R6" : "R5 R7 R11");
              end
            end
          end
        end
      end
    end

    // R12: a read/write slot with accValid low does not hit
    wrReg(3'd5, 32'h0000_0001 | (32'd3 << 16) | (32'd3 << 18));
    doEval(32'h0, 1'b0, 32'h1000, 2'd2, 1'b1, 1'b1, "R12");
    chk("R12 no hit without access", statusOut & 32'hF, 32'h0);
    // R5 control: the same access with accValid high does hit and trap
    doEval(32'h0, 1'b1, 32'h1000, 2'd2, 1'b1, 1'b0, "R5 R10");
    chk("R5 R10 trap on enabled hit", {31'd0, trapPulse}, 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule